// File: doc/BRIEF.md
# Fractional E1 Receive Clock Gater

This block produces the receive-side output clock and the frame indication for one E1 channel when that channel supplies its own timing. It runs on the line clock recovered upstream, one clock cycle per received bit, and is told where frames begin by a frame-start pulse from the upstream alignment logic. From these it keeps a bit-within-timeslot and timeslot-within-frame position. It then passes line clock pulses to the output only for the bits that downstream logic should take.

A 2-bit mode input selects the behaviour. With code 00 every bit of all 32 timeslots is clocked out. Code 01 is reserved and acts the same as 00. With code 10 only the timeslots whose bit is set in a 32-bit mask are clocked out. With code 11 the mask applies as well, and timeslot 0, which carries the framing bits, is always clocked out. The gating decision is taken while the line clock is low, so the output never carries a shortened pulse. A frame indication marks the first bit clocked out in each frame.

Top module: `frac_e1_rx_clk_gater`

## Requirements
- R1: While rst_ni is low, rx_clk_o and frame_o stay low. After reset is released, the first bit cycle is bit 0 of timeslot 0.
- R2: The position counts 8 bits per timeslot and 32 timeslots per frame, then wraps to bit 0 of timeslot 0. When frame_sync_i is high at a rising line clock edge, the bit of the following cycle is bit 0 of timeslot 0, wherever the count stood.
- R3: With mode_i equal to 00 or 01, the output pulses for every bit, giving 256 pulses per frame.
- R4: With mode_i equal to 10, the output pulses only for bits of timeslot n where mask_i[n] is 1. No pulse appears for a timeslot whose mask bit is 0.
- R5: With mode_i equal to 11, the 8 bits of timeslot 0 always pulse, whatever mask_i[0] holds. Every other timeslot follows its mask bit.
- R6: rx_clk_o is high only while clk_i is high. The output pulse for the bit held in a cycle is the high phase of clk_i that begins at the end of that cycle.
- R7: frame_o is high for exactly one line clock period per frame, aligned with the output pulse of the first bit clocked out in that frame. It never rises in a frame where no bit is clocked out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Line-side receive clock, one cycle per bit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_sync_i | input | 1 | Frame-start indication: the next bit is timeslot 0, bit 0 |
| mode_i | input | 2 | 00/01 full, 10 fractional, 11 fractional with framing timeslot |
| mask_i | input | 32 | Timeslot enable mask, bit n enables timeslot n |
| rx_clk_o | output | 1 | Gated receive output clock |
| frame_o | output | 1 | One-bit-wide frame indication |

## Verification
A wrong bit or timeslot count shows on rx_clk_o within one frame, and within one timeslot when the mask is sparse. The pulses shift to the wrong timeslot, and frame_o moves away from the expected bit index. A gate register that is stuck or latched on the wrong phase shows at once as a missing or extra pulse, or as output high while the line clock is low. Both are checked at every high and low phase. A first-bit tracker that is not cleared at frame start removes frame_o for the next frame. One that is never set raises frame_o on every enabled bit. The per-frame pulse counts and the index of the first marked bit expose both.

// File: rtl/frac_e1_pkg.sv
package frac_e1_pkg;

  typedef enum logic [1:0] {
    MODE_ALL      = 2'b00,
    MODE_ALL_ALT  = 2'b01,
    MODE_MASKED   = 2'b10,
    MODE_MASKED_F = 2'b11
  } rx_mode_e;

  // Decide whether the bits of one timeslot are passed to the output clock.
  function automatic logic slot_passes(input rx_mode_e mode,
                                       input logic     mask_bit,
                                       input logic     is_slot0);
    case (mode)
      MODE_MASKED:   return mask_bit;
      MODE_MASKED_F: return mask_bit | is_slot0;
      default:       return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/e1_bit_position.sv
module e1_bit_position #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_sync_i,
  output logic [$clog2(SLOTS)-1:0] slot_o,
  output logic [$clog2(BITS)-1:0]  bit_o,
  output logic                     restart_o
);
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(BITS);

  logic last_bit, last_slot;

  assign last_bit  = (bit_o == BW'(BITS - 1));
  assign last_slot = (slot_o == SW'(SLOTS - 1));
  assign restart_o = frame_sync_i | (last_bit & last_slot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o <= '0;
      bit_o  <= '0;
    end else if (restart_o) begin
      slot_o <= '0;
      bit_o  <= '0;
    end else if (last_bit) begin
      bit_o  <= '0;
      slot_o <= slot_o + 1'b1;
    end else begin
      bit_o  <= bit_o + 1'b1;
    end
  end

  // R2
  bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_sync_i && !last_bit) |=> (bit_o == $past(bit_o) + 1'b1 && slot_o == $past(slot_o)));

  // R2
  sync_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_i |=> (bit_o == '0 && slot_o == '0));

endmodule

// File: rtl/e1_slot_select.sv
module e1_slot_select
  import frac_e1_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  rx_mode_e                 mode_i,
  input  logic [SLOTS-1:0]         mask_i,
  input  logic [$clog2(SLOTS)-1:0] slot_i,
  input  logic                     restart_i,
  output logic                     pass_o,
  output logic                     first_o
);
  logic seen_q;

  assign pass_o  = slot_passes(mode_i, mask_i[slot_i], slot_i == '0);
  assign first_o = pass_o & ~seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= 1'b0;
    else if (restart_i) seen_q <= 1'b0;
    else if (pass_o)    seen_q <= 1'b1;
  end

  // R7
  first_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_o && !restart_i) |=> !first_o);

endmodule

// File: rtl/e1_clk_gate_cell.sv
module e1_clk_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pass_i,
  input  logic first_i,
  output logic clk_o,
  output logic frame_o,
  output logic gate_o
);
  logic gate_q, frame_q;

  // The enable is taken on the falling edge so that it only changes while the clock is low.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      gate_q  <= pass_i;
      frame_q <= first_i;
    end
  end

  assign clk_o   = clk_i & gate_q;
  assign frame_o = frame_q;
  assign gate_o  = gate_q;

  // R7
  fi_in_pulse_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    frame_q |-> gate_q);

endmodule

// File: rtl/frac_e1_rx_clk_gater.sv
module frac_e1_rx_clk_gater
  import frac_e1_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int BITS  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_sync_i,
  input  logic [1:0]       mode_i,
  input  logic [SLOTS-1:0] mask_i,
  output logic             rx_clk_o,
  output logic             frame_o
);
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(BITS);

  logic [SW-1:0] slot_w;
  logic [BW-1:0] bit_w;
  logic          restart_w, pass_w, first_w, gate_w;
  rx_mode_e      mode_w;

  assign mode_w = rx_mode_e'(mode_i);

  e1_bit_position #(.SLOTS(SLOTS), .BITS(BITS)) pos_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_sync_i(frame_sync_i),
    .slot_o(slot_w), .bit_o(bit_w), .restart_o(restart_w)
  );

  e1_slot_select #(.SLOTS(SLOTS)) sel_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_w), .mask_i(mask_i),
    .slot_i(slot_w), .restart_i(restart_w), .pass_o(pass_w), .first_o(first_w)
  );

  e1_clk_gate_cell gate_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pass_i(pass_w), .first_i(first_w),
    .clk_o(rx_clk_o), .frame_o(frame_o), .gate_o(gate_w)
  );

  // R3
  full_mode_gate_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !mode_i[1] |=> gate_w);

  // R4
  masked_slot_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && !mask_i[slot_w]) |=> !gate_w);

  // R5
  fbit_slot0_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && slot_w == '0) |=> gate_w);

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!rx_clk_o && !frame_o));

endmodule

// File: tb/frac_e1_rx_clk_gater_tb_top.sv
module frac_e1_rx_clk_gater_tb_top;

  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] mask;
    int          pulses;
    int          first;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 32'h0000_0000, 256, 0},
    '{2'b01, 32'h0000_0000, 256, 0},
    '{2'b10, 32'h0000_0002,   8, 8},
    '{2'b10, 32'h8000_0001,  16, 0},
    '{2'b11, 32'h0000_0000,   8, 0},
    '{2'b11, 32'h0001_0000,  16, 0},
    '{2'b10, 32'h0000_0000,   0, -1},
    '{2'b10, 32'hFFFF_FFFF, 256, 0},
    '{2'b10, 32'h0000_F000,  32, 96}
  };

  logic clk = 1'b0;
  logic rst_n, fs;
  logic [1:0] mode;
  logic [31:0] mask;
  wire rx_clk, fo;

  int n_cmp = 0, n_bad = 0;
  int pos;
  bit seen, prev_fs, exp_clk, exp_fi, s_clk, s_fi, done = 1'b0;

  always #2 clk = ~clk;

  frac_e1_rx_clk_gater dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_sync_i(fs), .mode_i(mode),
    .mask_i(mask), .rx_clk_o(rx_clk), .frame_o(fo)
  );

  function automatic bit en_model(input bit [1:0] m, input bit [31:0] k, input int slot);
    if (m == 2'b10) return k[slot];
    if (m == 2'b11) return (slot == 0) ? 1'b1 : k[slot];
    return 1'b1;
  endfunction

  function automatic string req_of(input bit [1:0] m);
    if (m == 2'b10) return "R4";
    if (m == 2'b11) return "R5";
    return "R3";
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit f, input bit [1:0] m, input bit [31:0] k);
    @(posedge clk); #1;
    s_clk = rx_clk;
    s_fi  = fo;
    check(s_clk == exp_clk, req_of(mode), "output pulse", int'(s_clk), int'(exp_clk));
    check(s_fi == exp_fi, "R7", "frame indication", int'(s_fi), int'(exp_fi));
    if (prev_fs || pos == 255) pos = 0; else pos++;
    seen = (pos == 0) ? 1'b0 : (seen | exp_clk);
    fs = f; mode = m; mask = k; prev_fs = f;
    exp_clk = en_model(m, k, pos / 8);
    exp_fi  = exp_clk & !seen;
    #2;
    check(rx_clk == 1'b0, "R6", "output high while clock low", int'(rx_clk), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt, first, nfi;
    rst_n = 1'b0; fs = 1'b0; mode = 2'b00; mask = 32'h0;
    // R1: quiet outputs during reset, even in full mode
    repeat (4) begin
      @(posedge clk); #1;
      check(rx_clk == 1'b0, "R1", "rx clock in reset", int'(rx_clk), 0);
      check(fo == 1'b0, "R1", "frame in reset", int'(fo), 0);
    end
    @(posedge clk); #1;
    rst_n = 1'b1; pos = 0; seen = 1'b0; prev_fs = 1'b0;
    exp_clk = en_model(mode, mask, 0); exp_fi = exp_clk;
    step(1'b0, 2'b00, 32'h0);
    check(s_fi == 1'b1, "R1", "first bit after reset marked", int'(s_fi), 1);

    // Table-driven frames: pulses per frame and first marked bit index
    for (int v = 0; v < NV; v++) begin
      step(1'b1, VEC[v].mode, VEC[v].mask);
      step(1'b0, VEC[v].mode, VEC[v].mask);
      cnt = 0; first = -1; nfi = 0;
      for (int i = 0; i < 256; i++) begin
        step(1'b0, VEC[v].mode, VEC[v].mask);
        if (s_clk) cnt++;
        if (s_fi) begin nfi++; if (first < 0) first = i; end
      end
      check(cnt == VEC[v].pulses, req_of(VEC[v].mode), "pulses per frame", cnt, VEC[v].pulses);
      check(first == VEC[v].first, "R7", "first marked bit", first, VEC[v].first);
      check(nfi == ((VEC[v].pulses > 0) ? 1 : 0), "R7", "marks per frame", nfi, (VEC[v].pulses > 0) ? 1 : 0);
    end

    // R2: realign in the middle of a frame, timeslot 3 only
    repeat (50) step(1'b0, 2'b10, 32'h0000_0008);
    step(1'b1, 2'b10, 32'h0000_0008);
    step(1'b0, 2'b10, 32'h0000_0008);
    cnt = 0; first = -1;
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 2'b10, 32'h0000_0008);
      if (s_clk) cnt++;
      if (s_fi && first < 0) first = i;
    end
    check(cnt == 8, "R2", "pulses after realign", cnt, 8);
    check(first == 24, "R2", "realigned timeslot 3 start", first, 24);

    // R2: free running wrap without frame sync, full mode
    nfi = 0;
    for (int i = 0; i < 512; i++) begin
      step(1'b0, 2'b00, 32'h0);
      if (s_fi) nfi++;
    end
    check(nfi == 2, "R2", "frame marks over two free-running frames", nfi, 2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule